// File: doc/BRIEF.md
# Chained Page-Bounded DMA Engine

This block is a bus-mastering copy engine that moves 32-bit words between memory and one of eight device ports, so that the processor does not have to. Software fills a table of up to eight transfer requests. Each request names a device, a direction, a physical start address and a byte count. Software then starts the chain with a single write. For each request in turn, the engine checks that the request stays inside one 4096-byte page and is word aligned. It then asks a central arbiter for the bus, waits for the device to be ready, and issues one address phase. After that it moves the words in back-to-back beats and hands the bus back after the final word.

The engine raises one interrupt, either when the whole chain has completed or when something goes wrong. Three kinds of fault stop the chain: a misaligned request, a request that is empty or crosses a page, and a bus error response during a burst. The interrupt stays up until software clears the latched status bits by writing ones to them. The status word records which request failed and why.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0, the interrupt is low and no bus request is made.
- R2: Request i occupies two registers: offset 0x40+8i holds the start address, and offset 0x44+8i holds the control word. In the control word, bit 0 selects the direction (0 = device to memory, 1 = memory to device), bits 3:1 give the device number and bits 28:16 give the byte count. Writing offset 0x00 with bit 0 set starts a chain whose last index is taken from bits 6:4. The status word reads bit 0 busy, bit 1 done, bit 2 error, bit 3 alignment fault, bit 4 range fault, bit 5 bus fault and bits 10:8 the failing request index.
- R3: For each accepted request the engine raises bus_req and issues no address phase or data beat before bus_gnt is seen.
- R4: After the grant, the address phase waits for dev_ready. A data beat (mem_beat/dev_strobe) only occurs in a cycle where dev_ready is high.
- R5: Each request produces exactly one address phase carrying the start address and the direction (mem_write high for device-to-memory). It is followed by count/4 data beats that move the words in order.
- R6: After the last beat, bus_req drops and bus_rel pulses for one cycle.
- R7: Requests run in index order from 0 to the last index. After the last one completes, done is set, busy clears and irq rises.
- R8: A request whose address or count has either of its low two bits set raises error with the alignment fault and its index. It makes no bus request, and the rest of the chain is dropped. An alignment fault takes priority over a range fault.
- R9: A request with a zero count, or whose page offset plus count exceeds 4096, raises error with the range fault and its index, with no bus request. A request that ends exactly at a page end is valid.
- R10: mem_err during a beat cancels that beat and ends the burst with the bus released. Error is set with the bus fault and the request index, and no later request runs.
- R11: Writing status with bit 1 set clears done, and with bit 2 set clears error, the fault bits and the index. irq is the OR of done and error. A completion in the same cycle as a clear leaves the bit set.
- R12: A start write or a request-table write made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt: done or error latched |
| bus_req | output | 1 | Bus request to the arbiter, held for the burst |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rel | output | 1 | One-cycle pulse: bus handed back |
| mem_addr_valid | output | 1 | Address phase of a burst |
| mem_addr | output | 32 | Burst start address |
| mem_write | output | 1 | Burst writes memory (device to memory) |
| mem_beat | output | 1 | Data beat this cycle |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory |
| mem_err | input | 1 | Error response for the current beat |
| dev_sel | output | 3 | Device number of the active request |
| dev_to_dev | output | 1 | Active request moves data to the device |
| dev_ready | input | 1 | Device has data or can accept data |
| dev_strobe | output | 1 | Device word consumed or delivered |
| dev_rdata | input | 32 | Word from the device |
| dev_wdata | output | 32 | Word to the device |

## Verification
Completion of a chain and a software clear of the status word can land in the same clock edge. The bench provokes this by holding a write of ones to both clear bits on every cycle while a chain runs, so the coincidence is certain whatever the random grant and ready delays are. The set must win. The interrupt therefore has to appear for at least one cycle even though a clear is written on every edge. Once the clear is released, done must read back as 1. A second coincidence occurs when a start write or a table write arrives while a long burst is still running. The bench judges this by checking that the bus request count and the moved data match the original chain.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 32;
    localparam int CHAIN_DEPTH = 8;
    localparam int IDX_W       = $clog2(CHAIN_DEPTH);
    localparam int DEV_W       = 3;
    localparam int PAGE_BYTES  = 4096;
    localparam int PAGE_LSB    = $clog2(PAGE_BYTES);
    localparam int CNT_W       = PAGE_LSB + 1;
    localparam int WORD_BYTES  = DATA_W / 8;
    localparam int WB_LSB      = $clog2(WORD_BYTES);
    localparam int BEAT_W      = CNT_W - WB_LSB;
    localparam int REG_AW      = 8;

    // control word field positions
    localparam int CTL_DIR_BIT = 0;
    localparam int CTL_DEV_LSB = 1;
    localparam int CTL_CNT_LSB = 16;

    typedef struct packed {
        logic              to_dev;
        logic [DEV_W-1:0]  dev;
        logic [CNT_W-1:0]  bytes;
        logic [ADDR_W-1:0] addr;
    } desc_t;

    typedef struct packed {
        logic bus;
        logic range;
        logic align;
    } fault_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_REQ, S_WAIT_DEV, S_ADDR, S_XFER, S_RELEASE
    } seq_state_e;

    // alignment outranks range; empty or page-crossing is a range fault
    function automatic fault_t vet_desc(desc_t d);
        fault_t             f;
        logic [CNT_W:0]     end_off;
        f       = '0;
        end_off = {2'b00, d.addr[PAGE_LSB-1:0]} + {1'b0, d.bytes};
        if ((|d.addr[WB_LSB-1:0]) || (|d.bytes[WB_LSB-1:0]))
            f.align = 1'b1;
        else if (d.bytes == '0 || end_off > (CNT_W+1)'(PAGE_BYTES))
            f.range = 1'b1;
        return f;
    endfunction
endpackage

// File: rtl/dma_desc_table.sv
module dma_desc_table
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output desc_t             rd_desc
);
    desc_t table_w [CHAIN_DEPTH];

    for (genvar g = 0; g < CHAIN_DEPTH; g++) begin : g_ent
        desc_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                if (wr_ctl) begin
                    q.to_dev <= wr_data[CTL_DIR_BIT];
                    q.dev    <= wr_data[CTL_DEV_LSB +: DEV_W];
                    q.bytes  <= wr_data[CTL_CNT_LSB +: CNT_W];
                end else begin
                    q.addr   <= wr_data;
                end
            end
        end
        assign table_w[g] = q;
    end

    assign rd_desc = table_w[rd_idx];
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_last,
    input  desc_t             desc,
    input  logic              bus_gnt,
    input  logic              dev_ready,
    input  logic              mem_err,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_rel,
    output logic              addr_phase,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              burst_write,
    output logic              beat,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              to_dev,
    output logic              fin_ok,
    output logic              fin_err,
    output fault_t            fault
);
    seq_state_e        st_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [BEAT_W-1:0] left_q;
    logic              berr_q;
    fault_t            chk;

    assign chk = vet_desc(desc);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            idx_q  <= '0;
            last_q <= '0;
            left_q <= '0;
            berr_q <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    idx_q  <= '0;
                    last_q <= start_last;
                    berr_q <= 1'b0;
                    st_q   <= S_CHECK;
                end
                S_CHECK: if (|chk) begin
                    st_q <= S_IDLE;
                end else begin
                    left_q <= desc.bytes[CNT_W-1:WB_LSB];
                    st_q   <= S_REQ;
                end
                S_REQ:      if (bus_gnt)   st_q <= S_WAIT_DEV;
                S_WAIT_DEV: if (dev_ready) st_q <= S_ADDR;
                S_ADDR:     st_q <= S_XFER;
                S_XFER: if (dev_ready) begin
                    if (mem_err) begin
                        berr_q <= 1'b1;
                        st_q   <= S_RELEASE;
                    end else begin
                        left_q <= left_q - 1'b1;
                        if (left_q == BEAT_W'(1)) st_q <= S_RELEASE;
                    end
                end
                S_RELEASE: if (berr_q || idx_q == last_q) begin
                    st_q <= S_IDLE;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    st_q  <= S_CHECK;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign cur_idx     = idx_q;
    assign busy        = (st_q != S_IDLE);
    assign bus_req     = (st_q == S_REQ) || (st_q == S_WAIT_DEV) ||
                         (st_q == S_ADDR) || (st_q == S_XFER);
    assign bus_rel     = (st_q == S_RELEASE);
    assign addr_phase  = (st_q == S_ADDR);
    assign beat        = (st_q == S_XFER) && dev_ready;
    assign burst_addr  = desc.addr;
    assign burst_write = ~desc.to_dev;
    assign dev_sel     = desc.dev;
    assign to_dev      = desc.to_dev;
    assign fin_ok      = (st_q == S_RELEASE) && !berr_q && (idx_q == last_q);
    assign fin_err     = ((st_q == S_CHECK) && (|chk)) ||
                         ((st_q == S_RELEASE) && berr_q);

    always_comb begin
        fault = '0;
        if (st_q == S_CHECK)                  fault = chk;
        else if (st_q == S_RELEASE && berr_q) fault.bus = 1'b1;
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rel,
    output logic              mem_addr_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic              mem_beat,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              dev_to_dev,
    input  logic              dev_ready,
    output logic              dev_strobe,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata
);
    localparam logic [REG_AW-1:0] OFF_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_STAT  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_TABLE = 8'h40;
    localparam logic [REG_AW-1:0] TABLE_SPAN = REG_AW'(8 * CHAIN_DEPTH);
    localparam int ST_DONE = 1, ST_ERR = 2, ST_FAULT_LSB = 3, ST_IDX_LSB = 8;

    logic              busy, fin_ok, fin_err;
    logic [IDX_W-1:0]  cur_idx;
    fault_t            fault;
    desc_t             cur_desc;
    logic [REG_AW-1:0] tbl_off;
    logic              tbl_hit, ctrl_wr, stat_wr;

    logic              done_q, err_q;
    fault_t            fault_q;
    logic [IDX_W-1:0]  eidx_q;

    assign tbl_off = reg_addr - OFF_TABLE;
    assign tbl_hit = reg_we && !busy && (reg_addr >= OFF_TABLE) &&
                     (tbl_off < TABLE_SPAN) && (tbl_off[1:0] == 2'b00);
    assign ctrl_wr = reg_we && (reg_addr == OFF_CTRL);
    assign stat_wr = reg_we && (reg_addr == OFF_STAT);

    dma_desc_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_hit),
        .wr_idx  (tbl_off[3 +: IDX_W]),
        .wr_ctl  (tbl_off[2]),
        .wr_data (reg_wdata),
        .rd_idx  (cur_idx),
        .rd_desc (cur_desc)
    );

    dma_xfer_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (ctrl_wr && reg_wdata[0] && !busy),
        .start_last  (reg_wdata[4 +: IDX_W]),
        .desc        (cur_desc),
        .bus_gnt     (bus_gnt),
        .dev_ready   (dev_ready),
        .mem_err     (mem_err),
        .cur_idx     (cur_idx),
        .busy        (busy),
        .bus_req     (bus_req),
        .bus_rel     (bus_rel),
        .addr_phase  (mem_addr_valid),
        .burst_addr  (mem_addr),
        .burst_write (mem_write),
        .beat        (mem_beat),
        .dev_sel     (dev_sel),
        .to_dev      (dev_to_dev),
        .fin_ok      (fin_ok),
        .fin_err     (fin_err),
        .fault       (fault)
    );

    // data steering: the beat strobes both sides at once
    assign dev_strobe = mem_beat;
    assign mem_wdata  = dev_rdata;
    assign dev_wdata  = mem_rdata;

    // latched status: a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            fault_q <= '0;
            eidx_q  <= '0;
        end else begin
            if (stat_wr && reg_wdata[ST_DONE]) done_q <= 1'b0;
            if (stat_wr && reg_wdata[ST_ERR]) begin
                err_q   <= 1'b0;
                fault_q <= '0;
                eidx_q  <= '0;
            end
            if (fin_ok) done_q <= 1'b1;
            if (fin_err) begin
                err_q   <= 1'b1;
                fault_q <= fault;
                eidx_q  <= cur_idx;
            end
        end
    end

    assign irq = done_q | err_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_STAT) begin
            reg_rdata[0]                 = busy;
            reg_rdata[ST_DONE]           = done_q;
            reg_rdata[ST_ERR]            = err_q;
            reg_rdata[ST_FAULT_LSB +: 3] = fault_q;
            reg_rdata[ST_IDX_LSB +: IDX_W] = eidx_q;
        end
    end
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk (
    input logic clk,
    input logic rst,
    input logic bus_req,
    input logic bus_gnt,
    input logic bus_rel,
    input logic mem_addr_valid,
    input logic mem_beat,
    input logic dev_ready,
    input logic irq,
    input logic busy
);
    // R3
    addr_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        mem_addr_valid |-> (bus_req && bus_gnt));

    // R4
    beat_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_beat |-> dev_ready);

    // R5
    single_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_addr_valid |=> (!mem_addr_valid && bus_req));

    // R6
    rel_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> bus_rel);

    // R6
    rel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rel |=> !bus_rel);

    // R7
    irq_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !busy);
endmodule

bind dma_chain_engine dma_chain_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_req        (bus_req),
    .bus_gnt        (bus_gnt),
    .bus_rel        (bus_rel),
    .mem_addr_valid (mem_addr_valid),
    .mem_beat       (mem_beat),
    .dev_ready      (dev_ready),
    .irq            (irq),
    .busy           (busy)
);

// File: tb/tb_dma_chain_engine.sv
module tb_dma_chain_engine;
    import dma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;
    localparam int MEM_WORDS  = 4096;
    localparam int LOG_MAX    = 4096;

    logic        clk, rst;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        irq, bus_req, bus_gnt, bus_rel;
    logic        mem_addr_valid, mem_write, mem_beat, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  dev_sel;
    logic        dev_to_dev, dev_ready, dev_strobe;
    logic [31:0] dev_rdata, dev_wdata;

    dma_chain_engine dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rel(bus_rel),
        .mem_addr_valid(mem_addr_valid), .mem_addr(mem_addr),
        .mem_write(mem_write), .mem_beat(mem_beat), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .dev_sel(dev_sel),
        .dev_to_dev(dev_to_dev), .dev_ready(dev_ready),
        .dev_strobe(dev_strobe), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fill(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // ---------------- models: memory, devices, arbiter ----------------
    logic [31:0] mem [MEM_WORDS];
    logic [31:0] sink_log [LOG_MAX];
    logic [11:0] ptr;
    int src_cnt [8];
    int sink_n, beats_run, reqs_run, rels_run, addrs_run;
    logic req_d;
    int inject_at = -1;
    bit stall_mode = 1'b1;

    assign mem_rdata = mem[ptr];
    assign dev_rdata = {dev_sel, 1'b0, 28'(src_cnt[dev_sel])};
    assign mem_err   = (inject_at >= 0) && (beats_run == inject_at);

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= fill(i);
            for (int i = 0; i < 8; i++) src_cnt[i] <= 0;
            ptr <= '0; sink_n <= 0; beats_run <= 0; reqs_run <= 0;
            rels_run <= 0; addrs_run <= 0; req_d <= 1'b0;
        end else begin
            req_d <= bus_req;
            if (bus_req && !req_d) reqs_run <= reqs_run + 1;
            if (bus_rel) rels_run <= rels_run + 1;
            if (mem_addr_valid) begin
                ptr <= mem_addr[13:2];
                addrs_run <= addrs_run + 1;
            end
            if (mem_beat) begin
                beats_run <= beats_run + 1;
                if (!mem_err) begin
                    ptr <= ptr + 1'b1;
                    if (mem_write) begin
                        mem[ptr] <= mem_wdata;
                        src_cnt[dev_sel] <= src_cnt[dev_sel] + 1;
                    end else begin
                        sink_log[sink_n] <= dev_wdata;
                        sink_n <= sink_n + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        dev_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
        if (!bus_req)      bus_gnt = 1'b0;
        else if (!bus_gnt) bus_gnt = (($urandom % 3) == 0);
    end

    // ---------------- bench-side prediction ----------------
    logic [31:0] shadow [MEM_WORDS];
    logic [31:0] sink_exp [LOG_MAX];
    int src_pred [8];
    logic [31:0] d_addr [8];
    int d_bytes [8], d_dev [8];
    bit d_to_dev [8];

    int exp_stat, exp_reqs, exp_words, exp_sink_n, sink_base, snap_reqs, snap_rels, snap_addrs, snap_beats;

    // 0 ok, 1 alignment, 2 range (R8, R9)
    function automatic int vet(input int i);
        int off;
        off = int'(d_addr[i][11:0]);
        if (d_addr[i][1:0] != 0 || (d_bytes[i] % 4) != 0) return 1;
        if (d_bytes[i] == 0 || off + d_bytes[i] > 4096) return 2;
        return 0;
    endfunction

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl_word(input int i);
        return (32'(d_bytes[i]) << 16) | (32'(d_dev[i]) << 1) | 32'(d_to_dev[i]);
    endfunction

    task automatic chain_prog(input int n, input int err_req, input int err_word);
        int k, done_words, f;
        bit stop;
        for (int i = 0; i < n; i++) begin
            reg_write(8'h40 + 8'(8*i), d_addr[i]);
            reg_write(8'h44 + 8'(8*i), ctl_word(i));
        end
        exp_reqs = 0; exp_words = 0; exp_sink_n = 0; done_words = 0;
        exp_stat = 32'h2; stop = 1'b0;
        snap_reqs = reqs_run; snap_rels = rels_run; snap_addrs = addrs_run;
        snap_beats = beats_run; sink_base = sink_n;
        inject_at = -1;
        for (int i = 0; i < n && !stop; i++) begin
            f = vet(i);
            if (f != 0) begin
                exp_stat = 32'h4 | (f == 1 ? 32'h8 : 32'h10) | (32'(i) << 8);
                stop = 1'b1;
            end else begin
                exp_reqs++;
                for (int w = 0; w < d_bytes[i] / 4 && !stop; w++) begin
                    k = (int'(d_addr[i][13:2]) + w) % MEM_WORDS;
                    if (i == err_req && w == err_word) begin
                        inject_at = snap_beats + done_words;
                        exp_stat = 32'h4 | 32'h20 | (32'(i) << 8);
                        stop = 1'b1;
                    end else begin
                        done_words++;
                        if (!d_to_dev[i]) begin
                            shadow[k] = {d_dev[i][2:0], 1'b0, 28'(src_pred[d_dev[i]])};
                            src_pred[d_dev[i]]++;
                        end else begin
                            sink_exp[exp_sink_n] = shadow[k];
                            exp_sink_n++;
                        end
                    end
                end
            end
        end
        exp_words = done_words;
    endtask

    task automatic wait_irq(input string tag);
        int t;
        t = 0;
        @(negedge clk);
        while (!irq && t < 20000) begin @(negedge clk); t++; end
        check({tag, " irq raised"}, 32'(irq), 32'h1);
    endtask

    task automatic chain_check(input string tag);
        logic [31:0] st;
        int bad;
        repeat (2) @(negedge clk);
        reg_read(8'h04, st);
        check({tag, " R7 R8 R9 R10 status"}, st, 32'(exp_stat));
        check({tag, " R3 bus requests"}, 32'(reqs_run - snap_reqs), 32'(exp_reqs));
        check({tag, " R6 releases"}, 32'(rels_run - snap_rels), 32'(exp_reqs));
        check({tag, " R5 address phases"}, 32'(addrs_run - snap_addrs), 32'(exp_reqs));
        check({tag, " R4 R5 words moved"}, 32'(beats_run - snap_beats),
              32'(exp_words + (inject_at >= 0 ? 1 : 0)));
        bad = 0;
        for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== shadow[i]) bad++;
        check({tag, " R2 R5 memory image mismatches"}, 32'(bad), 32'h0);
        check({tag, " R2 device sink count"}, 32'(sink_n - sink_base), 32'(exp_sink_n));
        bad = 0;
        for (int i = 0; i < exp_sink_n; i++)
            if (sink_log[sink_base + i] !== sink_exp[i]) bad++;
        check({tag, " R2 R5 device sink data"}, 32'(bad), 32'h0);
        bad = 0;
        for (int i = 0; i < 8; i++) if (src_cnt[i] != src_pred[i]) bad++;
        check({tag, " R10 device source counts"}, 32'(bad), 32'h0);
        reg_write(8'h04, 32'h6);
        @(negedge clk);
        check({tag, " R11 irq cleared"}, 32'(irq), 32'h0);
        reg_read(8'h04, st);
        check({tag, " R11 status cleared"}, st, 32'h0);
        inject_at = -1;
    endtask

    task automatic run_chain(input int n, input int err_req, input int err_word, input string tag);
        chain_prog(n, err_req, err_word);
        reg_write(8'h00, (32'(n - 1) << 4) | 32'h1);
        wait_irq(tag);
        chain_check(tag);
    endtask

    task automatic rand_req(input int i);
        int words, off;
        words = 1 + int'($urandom % 16);
        off   = int'($urandom % (1024 - words + 1));
        d_addr[i]   = 32'(int'($urandom % 4) * 4096 + off * 4);
        d_bytes[i]  = words * 4;
        d_dev[i]    = int'($urandom % 8);
        d_to_dev[i] = 1'($urandom % 2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] st;
        int t;
        void'($urandom(SEED));
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        dev_ready = 1'b0; bus_gnt = 1'b0;
        for (int i = 0; i < MEM_WORDS; i++) shadow[i] = fill(i);
        for (int i = 0; i < 8; i++) src_pred[i] = 0;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_read(8'h04, st);
        check("R1 status after reset", st, 32'h0);
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 no bus request after reset", 32'(bus_req), 32'h0);

        // random chains
        for (int r = 0; r < 8; r++) begin
            int n;
            n = 1 + int'($urandom % 8);
            stall_mode = (r % 3) != 2;
            for (int i = 0; i < n; i++) rand_req(i);
            run_chain(n, -1, 0, "random chain");
        end
        stall_mode = 1'b1;

        // R9 request ending exactly at page end, and a whole page
        d_addr[0] = 32'h0000_0FF0; d_bytes[0] = 16;   d_dev[0] = 2; d_to_dev[0] = 1'b0;
        d_addr[1] = 32'h0000_2000; d_bytes[1] = 4096; d_dev[1] = 5; d_to_dev[1] = 1'b0;
        d_addr[2] = 32'h0000_2FFC; d_bytes[2] = 4;    d_dev[2] = 1; d_to_dev[2] = 1'b1;
        run_chain(3, -1, 0, "R9 page end valid");

        // R9 page crossing at index 2
        for (int i = 0; i < 3; i++) rand_req(i);
        d_addr[2] = 32'h0000_1FF8; d_bytes[2] = 16;
        rand_req(3);
        run_chain(4, -1, 0, "R9 page crossing");

        // R9 zero count at index 0
        rand_req(0); d_bytes[0] = 0;
        rand_req(1);
        run_chain(2, -1, 0, "R9 zero count");

        // R8 misaligned address at index 1
        rand_req(0); rand_req(1); d_addr[1] = d_addr[1] | 32'h2;
        run_chain(2, -1, 0, "R8 misaligned address");

        // R8 misaligned count that also crosses: alignment wins
        rand_req(0); d_addr[0] = 32'h0000_0FFC; d_bytes[0] = 6;
        run_chain(1, -1, 0, "R8 alignment over range");

        // R10 bus error on third word of request 1
        for (int i = 0; i < 4; i++) rand_req(i);
        d_bytes[1] = 32; d_to_dev[1] = 1'b0;
        run_chain(4, 1, 2, "R10 bus error");

        // R10 bus error on first word of a read burst
        for (int i = 0; i < 2; i++) rand_req(i);
        d_to_dev[0] = 1'b1;
        run_chain(2, 0, 0, "R10 bus error first word");

        // R12 start and table write while busy are ignored
        d_addr[0] = 32'h0000_1000; d_bytes[0] = 1024; d_dev[0] = 3; d_to_dev[0] = 1'b0;
        d_addr[1] = 32'h0000_3100; d_bytes[1] = 16;   d_dev[1] = 4; d_to_dev[1] = 1'b0;
        chain_prog(2, -1, 0);
        reg_write(8'h00, 32'h11);
        repeat (6) @(negedge clk);
        reg_write(8'h00, 32'h01);
        reg_write(8'h4C, (32'd64 << 16) | (32'd4 << 1));
        wait_irq("R12 busy writes");
        chain_check("R12 busy writes ignored");

        // R11 completion coincides with a held clear: set wins
        rand_req(0);
        chain_prog(1, -1, 0);
        reg_write(8'h00, 32'h01);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h6;
        t = 0;
        while (!irq && t < 20000) begin @(negedge clk); t++; end
        reg_we = 1'b0;
        check("R11 irq seen despite held clear", 32'(irq), 32'h1);
        chain_check("R11 set wins over clear");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule